// File: doc/BRIEF.md
# Windowed Integer Register File

This block is an integer register file organised as a ring of overlapping register windows. Software sees 32 register numbers at a time. A current window pointer selects which slice of a larger physical array those numbers reach. Register numbers 0 to 7 always reach a small set of shared global registers. Numbers 8 to 31 reach storage that depends on the pointer, and adjacent windows share eight registers. Procedure arguments therefore move from caller to callee with no copy.

The array provides two combinational read ports and one clocked write port. A save command moves the pointer one window down the ring, and a restore command moves it one window up. A per-window invalid mask guards both moves. A move onto a window whose mask bit is set is refused, and the block pulses an overflow or underflow flag. Spilling, filling and trap entry are left to the surrounding core.

With the default parameters there are 8 global registers and 7 windows of 16 new registers each, which gives 120 physical registers.

Top module: `regwin_rf`

## Requirements
- R1: Register number 0 reads as zero on both read ports, and a write to it changes nothing that either port can read.
- R2: Register numbers 1 to 7 select the same global storage whatever the window pointer holds.
- R3: Reads are combinational. A write is stored on the rising clock edge when `wr_en` is high, and the new value is readable from the following cycle.
- R4: In the window at pointer N, registers 8 to 15 are the same storage as registers 24 to 31 of the window at pointer N-1 (mod 7), in the same order.
- R5: Registers 16 to 23 are private to their window. A write there is not visible in any other window.
- R6: An accepted save sets the pointer to N-1, and 0 wraps to 6. An accepted restore sets it to N+1, and 6 wraps to 0. The pointer always stays below 7.
- R7: A save whose target window has its mask bit set leaves the pointer unchanged. `window_overflow` is then high for exactly the one cycle after that edge.
- R8: A restore whose target window has its mask bit set leaves the pointer unchanged. `window_underflow` is then high for exactly the one cycle after that edge.
- R9: A write issued in the same cycle as a save is mapped through the pointer value from before the save.
- R10: Save and restore asserted together are ignored: the pointer does not change and no flag is raised.
- R11: After reset the pointer is 0, the mask is all zero, and both flags are low.
- R12: When `wim_we` is high, `wim_wdata` (bit i guards window i) loads the mask on the clock edge. A save or restore in that same cycle is checked against the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move back to the next higher window |
| wim_we | input | 1 | Load the invalid mask |
| wim_wdata | input | 7 | New invalid mask, one bit per window |
| cwp | output | 3 | Current window pointer |
| wim | output | 7 | Current invalid mask |
| window_overflow | output | 1 | Refused-save pulse |
| window_underflow | output | 1 | Refused-restore pulse |

## Verification
On every cycle the assertions check the pointer's step size and its wrap, that a refused move freezes the pointer and produces its flag, that the two flags never appear together, that a conflicting command pair has no effect, that the mask loads, and that register 0 reads as zero. The storage mapping cannot be checked that way: sharing between adjacent windows, the privacy of locals, the reach of the globals, and the use of the pre-save pointer for a write all appear only when the bench writes in one window and reads in another.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int unsigned GRP = 8;  // registers per group (globals, outs, locals, ins)

  typedef enum logic [1:0] {
    WCMD_NONE     = 2'd0,
    WCMD_SAVE     = 2'd1,
    WCMD_RESTORE  = 2'd2,
    WCMD_CONFLICT = 2'd3
  } wcmd_e;

  // Window below w in the ring (save direction).
  function automatic int unsigned win_dec(int unsigned w, int unsigned n);
    return (w == 0) ? n - 1 : w - 1;
  endfunction

  // Window above w in the ring (restore direction).
  function automatic int unsigned win_inc(int unsigned w, int unsigned n);
    return (w == n - 1) ? 0 : w + 1;
  endfunction

  // Physical slot for logical register lr seen from window w.
  // Window w owns 2*GRP slots after the globals: ins first, then locals.
  // Its outs are the ins of window w-1.
  function automatic int unsigned phys_slot(int unsigned lr, int unsigned w,
                                            int unsigned n, int unsigned ng);
    int unsigned off;
    off = lr % GRP;
    case (lr / GRP)
      0:       return lr;
      1:       return ng + 2 * GRP * win_dec(w, n) + off;
      2:       return ng + 2 * GRP * w + GRP + off;
      default: return ng + 2 * GRP * w + off;
    endcase
  endfunction

endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN  = 7,
  parameter int unsigned NGLOB = 8,
  parameter int unsigned CW    = 3,
  parameter int unsigned PW    = 7
) (
  input  logic [CW-1:0] cwp,
  input  logic [4:0]    laddr,
  output logic [PW-1:0] paddr,
  output logic          is_zero
);
  always_comb begin
    paddr   = PW'(phys_slot(32'(laddr), 32'(cwp), NWIN, NGLOB));
    is_zero = (laddr == 5'd0);
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 7,
  parameter int unsigned CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            wim_we,
  input  logic [NWIN-1:0] wim_wdata,
  output logic [CW-1:0]   cwp_q,
  output logic [NWIN-1:0] wim_q,
  output logic            ovf_q,
  output logic            unf_q,
  output logic            save_go,
  output logic            restore_go,
  output logic            save_blk,
  output logic            restore_blk
);
  wcmd_e         cmd;
  logic [CW-1:0] save_tgt, rest_tgt;

  always_comb begin
    cmd         = wcmd_e'({restore_req, save_req});
    save_tgt    = CW'(win_dec(32'(cwp_q), NWIN));
    rest_tgt    = CW'(win_inc(32'(cwp_q), NWIN));
    save_go     = (cmd == WCMD_SAVE)    && !wim_q[save_tgt];
    save_blk    = (cmd == WCMD_SAVE)    &&  wim_q[save_tgt];
    restore_go  = (cmd == WCMD_RESTORE) && !wim_q[rest_tgt];
    restore_blk = (cmd == WCMD_RESTORE) &&  wim_q[rest_tgt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      wim_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (save_go)         cwp_q <= save_tgt;
      else if (restore_go) cwp_q <= rest_tgt;
      if (wim_we) wim_q <= wim_wdata;
      ovf_q <= save_blk;
      unf_q <= restore_blk;
    end
  end
endmodule

// File: rtl/regwin_array.sv
module regwin_array #(
  parameter int unsigned DEPTH = 120,
  parameter int unsigned PW    = 7,
  parameter int unsigned XLEN  = 32
) (
  input  logic            clk,
  input  logic [PW-1:0]   ra_a,
  output logic [XLEN-1:0] rd_a,
  input  logic [PW-1:0]   ra_b,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [PW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/regwin_rf.sv
module regwin_rf
  import regwin_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NWIN  = 7,
  parameter int unsigned NGLOB = 8,
  localparam int unsigned NPHYS = NGLOB + 2 * GRP * NWIN,
  localparam int unsigned PW    = $clog2(NPHYS),
  localparam int unsigned CW    = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [4:0]      rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            wim_we,
  input  logic [NWIN-1:0] wim_wdata,
  output logic [CW-1:0]   cwp,
  output logic [NWIN-1:0] wim,
  output logic            window_overflow,
  output logic            window_underflow
);
  // Named internal events for the checker.
  logic save_go, restore_go, save_blk, restore_blk;
  logic wr_commit;

  logic [4:0]    laddr [3];
  logic [PW-1:0] paddr [3];
  logic          lzero [3];
  logic [XLEN-1:0] raw_a, raw_b;

  assign laddr[0] = rd_addr_a;
  assign laddr[1] = rd_addr_b;
  assign laddr[2] = wr_addr;

  regwin_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .save_req(save_req), .restore_req(restore_req),
    .wim_we(wim_we), .wim_wdata(wim_wdata),
    .cwp_q(cwp), .wim_q(wim),
    .ovf_q(window_overflow), .unf_q(window_underflow),
    .save_go(save_go), .restore_go(restore_go),
    .save_blk(save_blk), .restore_blk(restore_blk)
  );

  // One translator per port; all use the pointer before any update this cycle.
  for (genvar p = 0; p < 3; p++) begin : g_port
    regwin_xlate #(.NWIN(NWIN), .NGLOB(NGLOB), .CW(CW), .PW(PW)) u_xl (
      .cwp(cwp), .laddr(laddr[p]), .paddr(paddr[p]), .is_zero(lzero[p])
    );
  end

  assign wr_commit = wr_en && !lzero[2];

  regwin_array #(.DEPTH(NPHYS), .PW(PW), .XLEN(XLEN)) u_arr (
    .clk(clk),
    .ra_a(paddr[0]), .rd_a(raw_a),
    .ra_b(paddr[1]), .rd_b(raw_b),
    .we(wr_commit), .wa(paddr[2]), .wd(wr_data)
  );

  assign rd_data_a = lzero[0] ? '0 : raw_a;
  assign rd_data_b = lzero[1] ? '0 : raw_b;
endmodule

// File: rtl/regwin_rf_chk.sv
module regwin_rf_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NWIN = 7,
  parameter int unsigned CW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            save_req,
  input logic            restore_req,
  input logic            wim_we,
  input logic [NWIN-1:0] wim_wdata,
  input logic [4:0]      rd_addr_a,
  input logic [XLEN-1:0] rd_data_a,
  input logic [4:0]      rd_addr_b,
  input logic [XLEN-1:0] rd_data_b,
  input logic [CW-1:0]   cwp,
  input logic [NWIN-1:0] wim,
  input logic            window_overflow,
  input logic            window_underflow,
  input logic            save_go,
  input logic            restore_go,
  input logic            save_blk,
  input logic            restore_blk
);
  logic [CW-1:0] last_win;
  assign last_win = CW'(NWIN - 1);

  p_zero_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a == 5'd0 |-> rd_data_a == '0);
  p_zero_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_b == 5'd0 |-> rd_data_b == '0);

  p_cwp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cwp <= last_win);
  p_save_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    save_go |=> cwp == (($past(cwp) == '0) ? last_win : $past(cwp) - 1'b1));
  p_restore_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_go |=> cwp == (($past(cwp) == last_win) ? '0 : $past(cwp) + 1'b1));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    save_blk |=> window_overflow && $stable(cwp));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_blk |=> window_underflow && $stable(cwp));

  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(window_overflow && window_underflow));
  p_conflict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && restore_req |=> $stable(cwp) && !window_overflow && !window_underflow);

  p_wim_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wim_we |=> wim == $past(wim_wdata));
  p_wim_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wim_we |=> $stable(wim));
endmodule

bind regwin_rf regwin_rf_chk #(.XLEN(XLEN), .NWIN(NWIN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .save_req(save_req), .restore_req(restore_req),
  .wim_we(wim_we), .wim_wdata(wim_wdata),
  .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
  .cwp(cwp), .wim(wim),
  .window_overflow(window_overflow), .window_underflow(window_underflow),
  .save_go(save_go), .restore_go(restore_go),
  .save_blk(save_blk), .restore_blk(restore_blk)
);

// File: tb/regwin_rf_test.sv
module regwin_rf_test;
  localparam int NW = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, wim_we = 1'b0;
  logic [6:0]  wim_wdata = '0, wim;
  logic [2:0]  cwp;
  logic        window_overflow, window_underflow;

  int checks = 0;
  int errors = 0;
  int exp_cwp = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regwin_rf uut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .wim_we(wim_we), .wim_wdata(wim_wdata),
    .cwp(cwp), .wim(wim),
    .window_overflow(window_overflow), .window_underflow(window_underflow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int below(int w); return (w + NW - 1) % NW; endfunction
  function automatic int above(int w); return (w + 1) % NW; endfunction

  // One cycle: drive at the falling edge, release at the next falling edge.
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cmd(bit s, bit r);
    @(negedge clk); save_req = s; restore_req = r;
    @(negedge clk); save_req = 0; restore_req = 0;
  endtask

  task automatic load_wim(logic [6:0] m);
    @(negedge clk); wim_we = 1; wim_wdata = m;
    @(negedge clk); wim_we = 0;
  endtask

  function automatic logic [31:0] rd_a(logic [4:0] a);
    rd_addr_a = a;
    return 32'h0;
  endfunction

  task automatic peek(logic [4:0] a, output logic [31:0] v);
    rd_addr_a = a; rd_addr_b = a; #1; v = rd_data_a;
  endtask

  task automatic t_reset;
    chk("R11 cwp", 32'(cwp), 0);
    chk("R11 wim", 32'(wim), 0);
    chk("R11 flags", {30'd0, window_overflow, window_underflow}, 0);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    wr(5'd0, 32'hDEAD_BEEF);
    peek(5'd0, v);
    chk("R1 port A", v, 0);
    chk("R1 port B", rd_data_b, 0);
  endtask

  task automatic t_globals;
    logic [31:0] v;
    wr(5'd5, 32'h1111_0005);
    peek(5'd5, v); chk("R3 next-cycle read", v, 32'h1111_0005);
    cmd(1, 0); exp_cwp = below(exp_cwp);
    peek(5'd5, v); chk("R2 global after save", v, 32'h1111_0005);
    cmd(0, 1); exp_cwp = above(exp_cwp);
    chk("R6 back", 32'(cwp), 32'(exp_cwp));
  endtask

  task automatic t_overlap_r9;
    logic [31:0] v;
    // Write an out register together with a save: goes to the caller's out.
    @(negedge clk); wr_en = 1; wr_addr = 5'd9; wr_data = 32'hA9A9_0009; save_req = 1;
    @(negedge clk); wr_en = 0; save_req = 0; exp_cwp = below(exp_cwp);
    chk("R6 save", 32'(cwp), 32'(exp_cwp));
    peek(5'd25, v); chk("R9 out->in via pre-save cwp", v, 32'hA9A9_0009);
    wr(5'd30, 32'hB0B0_001E);
    cmd(0, 1); exp_cwp = above(exp_cwp);
    peek(5'd14, v); chk("R4 callee in -> caller out", v, 32'hB0B0_001E);
  endtask

  task automatic t_locals;
    logic [31:0] v;
    wr(5'd16, 32'hC0C0_0001);
    cmd(1, 0); exp_cwp = below(exp_cwp);
    wr(5'd16, 32'hC0C0_0002);
    peek(5'd16, v); chk("R5 callee local", v, 32'hC0C0_0002);
    cmd(0, 1); exp_cwp = above(exp_cwp);
    peek(5'd16, v); chk("R5 caller local kept", v, 32'hC0C0_0001);
  endtask

  task automatic t_wrap;
    cmd(1, 0); exp_cwp = below(exp_cwp);
    chk("R6 wrap 0->6", 32'(cwp), 32'(exp_cwp));
    chk("R6 value 6", 32'(cwp), 6);
    cmd(0, 1); exp_cwp = above(exp_cwp);
    chk("R6 wrap 6->0", 32'(cwp), 0);
    for (int i = 0; i < NW; i++) begin
      cmd(1, 0); exp_cwp = below(exp_cwp);
    end
    chk("R6 full ring", 32'(cwp), 0);
  endtask

  task automatic t_overflow;
    load_wim(7'(1 << below(exp_cwp)));
    cmd(1, 0);
    chk("R7 cwp held", 32'(cwp), 32'(exp_cwp));
    chk("R7 overflow pulse", {31'd0, window_overflow}, 1);
    chk("R7 no underflow", {31'd0, window_underflow}, 0);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, window_overflow}, 0);
  endtask

  task automatic t_underflow;
    load_wim(7'(1 << above(exp_cwp)));
    cmd(0, 1);
    chk("R8 cwp held", 32'(cwp), 32'(exp_cwp));
    chk("R8 underflow pulse", {31'd0, window_underflow}, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'd0, window_underflow}, 0);
    load_wim(7'd0);
  endtask

  task automatic t_conflict;
    cmd(1, 1);
    chk("R10 cwp held", 32'(cwp), 32'(exp_cwp));
    chk("R10 no flags", {30'd0, window_overflow, window_underflow}, 0);
  endtask

  task automatic t_wim_same;
    // Mask the save target in the same cycle as the save: old mask applies.
    @(negedge clk); wim_we = 1; wim_wdata = 7'(1 << below(exp_cwp)); save_req = 1;
    @(negedge clk); wim_we = 0; save_req = 0; exp_cwp = below(exp_cwp);
    chk("R12 save uses old mask", 32'(cwp), 32'(exp_cwp));
    chk("R12 no overflow", {31'd0, window_overflow}, 0);
    chk("R12 mask loaded", 32'(wim), 32'(1 << exp_cwp));
    load_wim(7'd0);
  endtask

  initial begin
    #3 t_reset();
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_zero();
    t_globals();
    t_overlap_r9();
    t_locals();
    t_wrap();
    t_overflow();
    t_underflow();
    t_conflict();
    t_wim_same();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule